// File: doc/BRIEF.md
# SDRAM Refresh Scheduler with Self-Refresh Control

This block keeps a four-bank SDRAM refreshed on behalf of a memory controller. An interval timer derived from the clock frequency adds one owed refresh per interval. The slow interval (about 15.6 µs) covers 4,096 rows in 64 ms. A select input switches to a quarter-length interval for high-temperature operation. Owed refreshes are counted up to a fixed cap, so the controller can defer them while it is busy and have them issued back-to-back once it releases the bus with all banks precharged.

Each AUTO REFRESH issue opens a recovery window. During that window only NOP or COMMAND INHIBIT may reach the device, and a status output tells the controller to hold off. On request, and only with all banks idle, the block issues a SELF REFRESH command and drives CKE low. It keeps CKE low until the request drops. On exit it opens a recovery window, restarts the interval timer and owes one catch-up refresh, so that AUTO REFRESH resumes inside one slow interval. A two-bit partial-array selection is decoded into a bank mask, captured at entry and held for the whole stay in self refresh.

Top module: `sdram_refresh_sched`

## Requirements
- R1: With `fast_period_i`=0, one refresh becomes owed every NORM_CYC = floor(CLK_MHZ*15625/1000) cycles, counted from reset release, from self-refresh exit or from the previous interval. With no other activity, the first `ref_cmd_o` appears NORM_CYC+1 cycles after reset release.
- R2: With `fast_period_i`=1 the interval is FAST_CYC = floor(NORM_CYC/4) cycles.
- R3: `ref_cmd_o` is a one-cycle pulse. It is issued one cycle after an edge at which all of these hold: `owed_o`>0, `banks_idle_i`=1, `busy_i`=0, no recovery window open, not in self refresh and `sr_req_i`=0. Each issue lowers `owed_o` by one.
- R4: `owed_o` saturates at DEBT_MAX. Intervals that expire while it is at DEBT_MAX are lost. `ref_req_o` is 1 exactly when `owed_o`>0 outside self refresh.
- R5: `in_refresh_o` is high for REC_CYC cycles, starting in the cycle of `ref_cmd_o`. No `ref_cmd_o` or `sr_cmd_o` is issued while it is high, so back-to-back refreshes are spaced REC_CYC+1 cycles apart.
- R6: A self-refresh entry needs `sr_req_i`=1 under the same bus conditions as R3, and takes priority over an owed refresh. It gives a one-cycle `sr_cmd_o`, with `cke_o` falling in the same cycle and `owed_o` cleared. While `cke_o` is low no refresh is owed or issued.
- R7: When `sr_req_i` drops during self refresh, `cke_o` rises the next cycle together with `in_refresh_o`, and `owed_o`=1. The catch-up `ref_cmd_o` follows REC_CYC+1 cycles after the exit cycle if the bus is free.
- R8: At entry, `pasr_cfg_i` is decoded onto `pasr_o` and held until the next entry. The codes are: 00 all banks (1111), 01 banks 0-1 (0011), 10 bank 0 (0001), 11 treated as all banks (1111).
- R9: In reset: `cke_o`=1, `pasr_o`=1111, and `ref_req_o`, `ref_cmd_o`, `sr_cmd_o`, `in_refresh_o` and `owed_o` are all 0.
- R10: When an interval expires at the same edge as an issue, `owed_o` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_period_i | input | 1 | 1 selects the quarter-length refresh interval |
| busy_i | input | 1 | Controller is using the command bus |
| banks_idle_i | input | 1 | All banks precharged |
| sr_req_i | input | 1 | Level request to stay in self refresh |
| pasr_cfg_i | input | 2 | Partial-array self-refresh selection |
| ref_req_o | output | 1 | At least one refresh owed |
| ref_cmd_o | output | 1 | Issue AUTO REFRESH this cycle |
| sr_cmd_o | output | 1 | Issue SELF REFRESH this cycle |
| cke_o | output | 1 | Clock enable to the device |
| in_refresh_o | output | 1 | Recovery window open, only NOP allowed |
| owed_o | output | $clog2(DEBT_MAX+1) | Owed refresh count |
| pasr_o | output | 4 | Bank mask kept during self refresh |

## Verification
The bench builds the block with CLK_MHZ=2, REC_CYC=3 and DEBT_MAX=8. This gives a 31-cycle slow interval and a 7-cycle fast interval, so saturation of the owed count lies a few hundred cycles away. Coincidences of an interval expiry with an issue, a self-refresh entry or an exit then happen many times during a random run of some thousands of cycles. The short recovery window makes back-to-back spacing and catch-up timing easy to measure directly.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic {ST_RUN = 1'b0, ST_SELF = 1'b1} sr_state_e;

  function automatic logic [3:0] pasr_mask(input logic [1:0] code);
    case (code)
      2'b01:   return 4'b0011;
      2'b10:   return 4'b0001;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
  parameter int unsigned NORM_CYC = 1562,
  parameter int unsigned FAST_CYC = 390,
  parameter int unsigned CNT_W    = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  input  logic fast_i,
  output logic tick_o
);
  localparam logic [CNT_W-1:0] NORM_LAST = CNT_W'(NORM_CYC - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_CYC - 1);

  logic [CNT_W-1:0] cnt_q, last;

  assign last   = fast_i ? FAST_LAST : NORM_LAST;
  // >= so a switch to the short period never overshoots
  assign tick_o = run_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (run_i)     cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end

  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= NORM_LAST);
  assert_restart_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !tick_o);
endmodule

// File: rtl/rfs_debt_counter.sv
module rfs_debt_counter #(
  parameter int unsigned DEBT_MAX = 8,
  parameter int unsigned W        = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         dec_i,
  input  logic         clr_i,
  input  logic         set_one_i,
  output logic [W-1:0] owed_o
);
  localparam logic [W-1:0] MAX_L = W'(DEBT_MAX);

  logic [W-1:0] owed_q;
  assign owed_o = owed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                owed_q <= '0;
    else if (clr_i)                             owed_q <= '0;
    else if (set_one_i)                         owed_q <= W'(1);
    else if (inc_i && !dec_i && owed_q != MAX_L) owed_q <= owed_q + 1'b1;
    else if (dec_i && !inc_i)                   owed_q <= owed_q - 1'b1;
  end

  assert_owed_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owed_q <= MAX_L);
  assert_sat_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i && !clr_i && !set_one_i && owed_q == MAX_L) |=> owed_q == MAX_L);
  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> owed_q != '0);
  assert_tick_grant_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && dec_i && !clr_i && !set_one_i) |=> $stable(owed_q));
endmodule

// File: rtl/rfs_hold_timer.sv
module rfs_hold_timer #(
  parameter int unsigned CYC = 7,
  parameter int unsigned W   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic active_o
);
  localparam logic [W-1:0] CYC_L = W'(CYC);

  logic [W-1:0] cnt_q;
  assign active_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (load_i)   cnt_q <= CYC_L;
    else if (active_o) cnt_q <= cnt_q - 1'b1;
  end

  assert_load_when_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !active_o);
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int unsigned CLK_MHZ  = 100,
  parameter int unsigned DEBT_MAX = 8,
  parameter int unsigned REC_CYC  = 7
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          fast_period_i,
  input  logic                          busy_i,
  input  logic                          banks_idle_i,
  input  logic                          sr_req_i,
  input  logic [1:0]                    pasr_cfg_i,
  output logic                          ref_req_o,
  output logic                          ref_cmd_o,
  output logic                          sr_cmd_o,
  output logic                          cke_o,
  output logic                          in_refresh_o,
  output logic [$clog2(DEBT_MAX+1)-1:0] owed_o,
  output logic [3:0]                    pasr_o
);
  import rfs_pkg::*;

  localparam int unsigned NORM_CYC = (CLK_MHZ * 15625) / 1000;
  localparam int unsigned FAST_CYC = NORM_CYC / 4;
  localparam int unsigned CNT_W    = $clog2(NORM_CYC + 1);
  localparam int unsigned OWED_W   = $clog2(DEBT_MAX + 1);
  localparam int unsigned HOLD_W   = $clog2(REC_CYC + 1);

  sr_state_e         st_q;
  logic              cke_q, cmd_q, srcmd_q;
  logic [3:0]        pasr_q;
  logic              tick, hold_active, bus_free, enter, leave, grant;
  logic [OWED_W-1:0] owed;

  assign bus_free = (st_q == ST_RUN) && !hold_active && !busy_i && banks_idle_i;
  assign enter    = bus_free && sr_req_i;
  assign leave    = (st_q == ST_SELF) && !sr_req_i;
  assign grant    = bus_free && !sr_req_i && (owed != '0);

  rfs_interval_timer #(.NORM_CYC(NORM_CYC), .FAST_CYC(FAST_CYC), .CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni,
    .run_i(st_q == ST_RUN), .restart_i(leave), .fast_i(fast_period_i), .tick_o(tick)
  );

  rfs_debt_counter #(.DEBT_MAX(DEBT_MAX), .W(OWED_W)) u_debt (
    .clk_i, .rst_ni,
    .inc_i(tick), .dec_i(grant), .clr_i(enter), .set_one_i(leave), .owed_o(owed)
  );

  rfs_hold_timer #(.CYC(REC_CYC), .W(HOLD_W)) u_hold (
    .clk_i, .rst_ni, .load_i(grant || leave), .active_o(hold_active)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_RUN;
      cke_q   <= 1'b1;
      cmd_q   <= 1'b0;
      srcmd_q <= 1'b0;
      pasr_q  <= 4'b1111;
    end else begin
      cmd_q   <= grant;
      srcmd_q <= enter;
      if (enter) begin
        st_q   <= ST_SELF;
        cke_q  <= 1'b0;
        pasr_q <= pasr_mask(pasr_cfg_i);
      end else if (leave) begin
        st_q  <= ST_RUN;
        cke_q <= 1'b1;
      end
    end
  end

  assign ref_req_o    = (owed != '0) && (st_q == ST_RUN);
  assign ref_cmd_o    = cmd_q;
  assign sr_cmd_o     = srcmd_q;
  assign cke_o        = cke_q;
  assign in_refresh_o = hold_active;
  assign owed_o       = owed;
  assign pasr_o       = pasr_q;

  assert_grant_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_cmd_o |-> $past(banks_idle_i && !busy_i && !sr_req_i));
  assert_ref_opens_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_cmd_o |-> in_refresh_o);
  assert_window_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_cmd_o |=> !ref_cmd_o && !sr_cmd_o);
  assert_no_ref_in_self_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> !ref_cmd_o && !ref_req_o);
  assert_cke_fall_cmd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> sr_cmd_o);
  assert_catchup_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> ref_req_o && in_refresh_o);
  assert_pasr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && $past(!cke_o)) |-> $stable(pasr_o));
endmodule

// File: tb/tb_sdram_refresh_sched.sv
`timescale 1ns/1ps
module tb_sdram_refresh_sched;
  localparam int CLK_MHZ = 2;
  localparam int DMAX    = 8;
  localparam int REC     = 3;
  localparam int NORM    = (CLK_MHZ * 15625) / 1000; // 31
  localparam int FAST    = NORM / 4;                 // 7

  logic clk = 1'b0, rst_n = 1'b0;
  logic fast = 1'b0, busy = 1'b0, idle = 1'b1, sr_req = 1'b0;
  logic [1:0] pasr_cfg = 2'b00;
  logic ref_req, ref_cmd, sr_cmd, cke, in_ref;
  logic [3:0] owed, pasr;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sdram_refresh_sched #(.CLK_MHZ(CLK_MHZ), .DEBT_MAX(DMAX), .REC_CYC(REC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .fast_period_i(fast), .busy_i(busy),
    .banks_idle_i(idle), .sr_req_i(sr_req), .pasr_cfg_i(pasr_cfg),
    .ref_req_o(ref_req), .ref_cmd_o(ref_cmd), .sr_cmd_o(sr_cmd), .cke_o(cke),
    .in_refresh_o(in_ref), .owed_o(owed), .pasr_o(pasr)
  );

  function automatic logic [3:0] exp_mask(input logic [1:0] c);
    if (c == 2'b01) return 4'b0011;
    if (c == 2'b10) return 4'b0001;
    return 4'b1111;
  endfunction

  // reference model built from the requirements
  int m_cnt, m_owed, m_rfc;
  bit m_self, m_cmd, m_srcmd;
  logic [3:0] m_pasr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_owed = 0; m_rfc = 0; m_self = 0; m_cmd = 0; m_srcmd = 0; m_pasr = 4'b1111;
    end else begin
      int lim; bit tk, fr, en, lv, gr;
      lim = fast ? FAST : NORM;
      tk  = !m_self && (m_cnt >= lim - 1);
      fr  = !m_self && (m_rfc == 0) && !busy && idle;
      en  = fr && sr_req;
      lv  = m_self && !sr_req;
      gr  = fr && !sr_req && (m_owed > 0);
      if (lv) m_cnt = 0;
      else if (!m_self) m_cnt = tk ? 0 : m_cnt + 1;
      if (en) m_owed = 0;
      else if (lv) m_owed = 1;
      else if (tk && !gr) m_owed = (m_owed < DMAX) ? m_owed + 1 : DMAX;
      else if (gr && !tk) m_owed = m_owed - 1;
      if (gr || lv) m_rfc = REC; else if (m_rfc > 0) m_rfc = m_rfc - 1;
      if (en) begin m_self = 1; m_pasr = exp_mask(pasr_cfg); end
      else if (lv) m_self = 0;
      m_cmd = gr; m_srcmd = en;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (rst_n) begin
      chk("R1/R4 ref_req_o", int'(ref_req), int'(m_owed > 0 && !m_self));
      chk("R3 ref_cmd_o", int'(ref_cmd), int'(m_cmd));
      chk("R6 sr_cmd_o", int'(sr_cmd), int'(m_srcmd));
      chk("R6/R7 cke_o", int'(cke), int'(!m_self));
      chk("R5 in_refresh_o", int'(in_ref), int'(m_rfc > 0));
      chk("R4/R10 owed_o", int'(owed), m_owed);
      chk("R8 pasr_o", int'(pasr), int'(m_pasr));
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R9 reset cke", int'(cke), 1);
    chk("R9 reset pasr", int'(pasr), 15);
    chk("R9 reset outputs", int'({ref_req, ref_cmd, sr_cmd, in_ref}), 0);
    chk("R9 reset owed", int'(owed), 0);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    int n, gap;
    void'($urandom(32'd24681));
    do_reset();

    // R1: first refresh issued NORM+1 cycles after release
    n = 0;
    do begin step(); n++; end while (!ref_cmd && n < 200);
    chk("R1 first ref_cmd cycle", n, NORM + 1);

    // R4: saturation while busy
    busy = 1'b1;
    repeat (9 * NORM + 5) step();
    chk("R4 owed saturated", int'(owed), DMAX);
    busy = 1'b0;

    // R5: back-to-back spacing
    n = 0;
    do begin step(); n++; end while (!ref_cmd && n < 20);
    for (int k = 0; k < 2; k++) begin
      gap = 0;
      do begin step(); gap++; end while (!ref_cmd && gap < 20);
      chk("R5 refresh spacing", gap, REC + 1);
    end

    // R2: fast interval from reset
    fast = 1'b1; busy = 1'b1;
    do_reset();
    repeat (3 * FAST) step();
    chk("R2 fast interval owed", int'(owed), 3);

    // R6: entry beats owed refresh
    busy = 1'b0; sr_req = 1'b1; pasr_cfg = 2'b01;
    step();
    chk("R6 entry cmd", int'(sr_cmd), 1);
    chk("R6 cke low", int'(cke), 0);
    chk("R6 owed cleared", int'(owed), 0);
    chk("R6 no refresh on entry", int'(ref_cmd), 0);
    pasr_cfg = 2'b10;
    repeat (40) step();
    chk("R8 mask held", int'(pasr), 4'b0011);
    chk("R6 nothing owed in self", int'(owed), 0);

    // R7: exit and catch-up
    sr_req = 1'b0;
    step();
    chk("R7 cke high", int'(cke), 1);
    chk("R7 owed one", int'(owed), 1);
    chk("R7 recovery open", int'(in_ref), 1);
    n = 0;
    do begin step(); n++; end while (!ref_cmd && n < 20);
    chk("R7 catch-up delay", n, REC + 1);

    // random traffic
    fast = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      busy = (($urandom % 100) < 35);
      idle = (($urandom % 100) < 85);
      if (($urandom % 300) == 0) sr_req = ~sr_req;
      if (($urandom % 1500) == 0) fast = ~fast;
      pasr_cfg = 2'($urandom % 4);
      step();
    end
    finish_run();
  end
endmodule